// File: doc/BRIEF.md
# CPU-Paced Buffer Byte Port

This block gives a CPU byte-at-a-time access to a buffer memory through one data register. The CPU first loads a start address into an address counter. It then writes a control register that turns the channel on and selects the direction. From that point, every access to the data register moves at most one byte between the register and the memory.

The CPU finds out when it may access the data register through two flags in a status register. In fetch direction the block reads the byte at the counter ahead of time and raises the fetch-ready flag. A CPU read of the data register takes that byte, advances the counter and starts the next fetch. In store direction the store-ready flag is up while the register is free. A CPU write fills the register, and the block then writes that byte to memory. When the memory acknowledges, the flag comes back and the counter advances. The counter moves only when a byte really crosses between the register and the memory.

The memory side uses a request/acknowledge pair with at most one cycle outstanding, so the block can sit behind any arbiter.

Top module: `cbuf_port`

## Requirements
- R1: After reset the address counter, the control register, the status register and the data register all read 0, and `memReq` is low.
- R2: Register select values: 0 is the address counter, loaded from the low ADDR_W bits of a write and read back zero-extended. 1 is control, with bit 3 = enable and bit 4 = direction (0 fetch from memory, 1 store to memory); every other control bit reads 0. 2 is status (read-only), with bit 1 = fetch-ready and bit 2 = store-ready; every other status bit reads 0. 3 is the data register. Reads of selects 0, 1 and 2 have no side effects.
- R3: A control write with enable=1 and direction=0 raises `memReq` with `memWe`=0 at the counter address on the next cycle. On the acknowledge edge the byte on `memRdata` is loaded into the data register and fetch-ready becomes 1.
- R4: A data-register read while fetch-ready is 1 returns the fetched byte, clears fetch-ready, increments the counter, and starts a fetch at the new address.
- R5: A data-register read while fetch-ready is 0 returns the current register value and changes neither the counter nor any flag.
- R6: A control write with enable=1 and direction=1 sets store-ready to 1 and starts no memory cycle.
- R7: A data-register write while store-ready is 1 captures the byte, clears store-ready and requests a memory write of that byte at the counter. On the acknowledge edge store-ready returns to 1 and the counter increments.
- R8: A data-register write while store-ready is 0 is ignored: the byte already waiting and the byte later stored are unchanged.
- R9: A control write with enable=0 drops `memReq` and both ready flags on the next cycle and leaves the counter unchanged. A store that has not yet been acknowledged is not performed.
- R10: The address counter wraps from 2^ADDR_W-1 to 0.
- R11: While a memory request waits for its acknowledge, `memReq`, `memWe`, `memAddr` and `memWdata` hold steady unless the channel is reprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select |
| regWr | input | 1 | CPU register write strobe |
| regRd | input | 1 | CPU register read strobe |
| regWdata | input | DATA_W | CPU write data |
| regRdata | output | DATA_W | Read data for the selected register (combinational) |
| memReq | output | 1 | Memory cycle request |
| memWe | output | 1 | Memory cycle is a write |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid with memAck |
| memAck | input | 1 | One-cycle acknowledge of the current request |

## Verification
The checker assumes three things about the inputs. `memAck` is high only while `memReq` is high and lasts one cycle per request. `regRd` and `regWr` are never high in the same cycle. Control is reprogrammed only by complete register writes. The bench follows all three. Its memory model registers the acknowledge after a programmable wait counted from a request it has seen, and clears it on the following edge. Every CPU access is a single one-cycle strobe of one kind, applied at the falling edge.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  // bit positions other logic decodes
  localparam int EN_BIT   = 3;
  localparam int DIR_BIT  = 4;
  localparam int FRDY_BIT = 1;
  localparam int SRDY_BIT = 2;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_FETCH,
    ST_HOLD,
    ST_IDLE,
    ST_STORE
  } cbufState_e;

  typedef struct packed {
    logic loadAddr;
    logic incAddr;
    logic loadFromMem;
    logic loadFromCpu;
  } cbufStrobe_t;
endpackage

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl
  import cbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regSel,
  input  logic        regWr,
  input  logic        regRd,
  input  logic        wrEnBit,
  input  logic        wrDirBit,
  input  logic        memAck,
  output cbufStrobe_t strobe,
  output logic        enQ,
  output logic        dirQ,
  output logic        fetchRdy,
  output logic        storeRdy,
  output logic        memReq,
  output logic        memWe
);
  cbufState_e stateQ, stateD;
  logic ctrlWr, dataRd, dataWr;

  assign ctrlWr = regWr && (regSel == SEL_CTRL);
  assign dataRd = regRd && (regSel == SEL_DATA);
  assign dataWr = regWr && (regSel == SEL_DATA);

  assign fetchRdy = (stateQ == ST_HOLD);
  assign storeRdy = (stateQ == ST_IDLE);
  assign memReq   = (stateQ == ST_FETCH) || (stateQ == ST_STORE);
  assign memWe    = (stateQ == ST_STORE);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    strobe.loadAddr = regWr && (regSel == SEL_ADDR);
    if (ctrlWr) begin
      if (!wrEnBit)      stateD = ST_OFF;
      else if (wrDirBit) stateD = ST_IDLE;
      else               stateD = ST_FETCH;
    end else begin
      unique case (stateQ)
        ST_FETCH: if (memAck) begin
          stateD = ST_HOLD;
          strobe.loadFromMem = 1'b1;
        end
        ST_HOLD: if (dataRd) begin
          stateD = ST_FETCH;
          strobe.incAddr = 1'b1;
        end
        ST_IDLE: if (dataWr) begin
          stateD = ST_STORE;
          strobe.loadFromCpu = 1'b1;
        end
        ST_STORE: if (memAck) begin
          stateD = ST_IDLE;
          strobe.incAddr = 1'b1;
        end
        default: stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
      enQ    <= 1'b0;
      dirQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ctrlWr) begin
        enQ  <= wrEnBit;
        dirQ <= wrDirBit;
      end
    end
  end
endmodule

// File: rtl/cbuf_datapath.sv
module cbuf_datapath
  import cbuf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbufStrobe_t       strobe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              enQ,
  input  logic              dirQ,
  input  logic              fetchRdy,
  input  logic              storeRdy,
  output logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (strobe.loadAddr)     addrQ <= regWdata[ADDR_W-1:0];
      else if (strobe.incAddr) addrQ <= addrQ + 1'b1;
      if (strobe.loadFromMem)      dataQ <= memRdata;
      else if (strobe.loadFromCpu) dataQ <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_ADDR: regRdata[ADDR_W-1:0] = addrQ;
      SEL_CTRL: begin
        regRdata[EN_BIT]  = enQ;
        regRdata[DIR_BIT] = dirQ;
      end
      SEL_STAT: begin
        regRdata[FRDY_BIT] = fetchRdy;
        regRdata[SRDY_BIT] = storeRdy;
      end
      default:  regRdata = dataQ;
    endcase
  end
endmodule

// File: rtl/cbuf_port.sv
module cbuf_port
  import cbuf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);
  cbufStrobe_t       strobe;
  logic              enQ, dirQ, fetchRdy, storeRdy;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  cbuf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWr    (regWr),
    .regRd    (regRd),
    .wrEnBit  (regWdata[EN_BIT]),
    .wrDirBit (regWdata[DIR_BIT]),
    .memAck   (memAck),
    .strobe   (strobe),
    .enQ      (enQ),
    .dirQ     (dirQ),
    .fetchRdy (fetchRdy),
    .storeRdy (storeRdy),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  cbuf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regSel   (regSel),
    .regWdata (regWdata),
    .memRdata (memRdata),
    .enQ      (enQ),
    .dirQ     (dirQ),
    .fetchRdy (fetchRdy),
    .storeRdy (storeRdy),
    .regRdata (regRdata),
    .addrQ    (addrQ),
    .dataQ    (dataQ)
  );

  assign memAddr  = addrQ;
  assign memWdata = dataQ;
endmodule

// File: rtl/cbuf_port_chk.sv
module cbuf_port_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regSel,
  input logic              regWr,
  input logic              regRd,
  input logic [DATA_W-1:0] regWdata,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic              fetchRdy,
  input logic              storeRdy
);
  logic ctrlWr, addrWr, dataRd, dataWr;
  assign ctrlWr = regWr && (regSel == 2'd1);
  assign addrWr = regWr && (regSel == 2'd0);
  assign dataRd = regRd && (regSel == 2'd3);
  assign dataWr = regWr && (regSel == 2'd3);

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fetchRdy, storeRdy, memReq}));

  p_fetch_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWdata[3] && !regWdata[4]) |=> (memReq && !memWe && !fetchRdy));

  p_consume_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && fetchRdy) |=>
      (!fetchRdy && memReq && !memWe && memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  p_stale_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !fetchRdy && !memAck) |=> $stable(memAddr));

  p_store_open_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWdata[3] && regWdata[4]) |=> (storeRdy && !memReq));

  p_store_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && storeRdy) |=> (!storeRdy && memReq && memWe && memWdata == $past(regWdata)));

  p_store_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck && !ctrlWr && !addrWr) |=>
      (storeRdy && memAddr == ADDR_W'($past(memAddr) + 1'b1)));

  p_store_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !storeRdy && memReq) |=> $stable(memWdata));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !regWdata[3]) |=> (!memReq && !fetchRdy && !storeRdy && $stable(memAddr)));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !ctrlWr && !addrWr) |=>
      (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));
endmodule

bind cbuf_port cbuf_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regSel   (regSel),
  .regWr    (regWr),
  .regRd    (regRd),
  .regWdata (regWdata),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memAck   (memAck),
  .fetchRdy (fetchRdy),
  .storeRdy (storeRdy)
);

// File: tb/cbuf_port_tb.sv
module cbuf_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    regSel;
  logic          regWr, regRd;
  logic [DW-1:0] regWdata, regRdata;
  logic          memReq, memWe, memAck;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;

  int nChecks = 0;
  int nErrors = 0;
  int lat = 0;
  int waitCnt;
  logic [DW-1:0] mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  cbuf_port #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  // memory model: acknowledge after lat waiting cycles, one cycle wide
  assign memRdata = mem[memAddr];
  always @(posedge clk) begin
    if (!rstN || !memReq || memAck) begin
      waitCnt <= 0;
      memAck  <= 1'b0;
    end else if (waitCnt == lat) begin
      memAck <= 1'b1;
    end else begin
      waitCnt <= waitCnt + 1;
    end
    if (rstN && memReq && memWe && memAck) mem[memAddr] <= memWdata;
  end

  function automatic logic [DW-1:0] patByte(int a);
    return DW'((a * 37 + 5) & 255);
  endfunction

  function automatic logic [DW-1:0] wrByte(int a, int l);
    return DW'((a * 11 + l * 53 + 1) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sel,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    @(negedge clk);
    regWr = wr; regRd = !wr; regSel = sel; regWdata = wd;
    #1 rd = regRdata;
    @(posedge clk);
    #1 regWr = 1'b0; regRd = 1'b0;
  endtask

  task automatic waitFlag(input int bitIdx, input string req);
    logic [DW-1:0] st;
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      access(1'b0, 2'd2, '0, st);
      seen = st[bitIdx];
    end
    chk(req, int'(seen), 1);
  endtask

  task automatic refill();
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) mem[i] = patByte(i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic [DW-1:0] prev;
    int start;
    rstN = 1'b0; regSel = '0; regWr = 1'b0; regRd = 1'b0; regWdata = '0;
    for (int i = 0; i < DEPTH; i++) mem[i] = patByte(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      access(1'b0, 2'(s), '0, rd);
      chk("R1 reset register", int'(rd), 0);
    end
    chk("R1 memReq after reset", int'(memReq), 0);

    // R2 register map and readback, R6 store direction opens
    access(1'b1, 2'd1, 8'hFF, rd);
    chk("R6 no memory cycle in store mode", int'(memReq), 0);
    access(1'b0, 2'd1, '0, rd);
    chk("R2 control readback", int'(rd), 8'h18);
    access(1'b0, 2'd2, '0, rd);
    chk("R6 store-ready after enable", int'(rd), 8'h04);
    access(1'b1, 2'd1, 8'h00, rd);
    access(1'b0, 2'd2, '0, rd);
    chk("R9 status after disable", int'(rd), 0);
    access(1'b1, 2'd0, 8'h3A, rd);
    access(1'b0, 2'd0, '0, rd);
    chk("R2 address load truncated", int'(rd), 8'h0A);

    for (int l = 0; l < 4; l++) begin
      lat = l;
      refill();
      // fetch sweep, crossing the wrap point (R10)
      start = (l * 5 + 9) % DEPTH;
      access(1'b1, 2'd0, DW'(start), rd);
      access(1'b1, 2'd1, 8'h08, rd);
      chk("R3 request after enable", int'(memReq && !memWe), 1);
      chk("R3 request address", int'(memAddr), start);
      for (int k = 0; k <= DEPTH; k++) begin
        waitFlag(1, "R3 fetch-ready rises");
        access(1'b0, 2'd3, '0, rd);
        prev = rd;
        chk("R4 fetched byte", int'(rd), int'(patByte((start + k) % DEPTH)));
        access(1'b0, 2'd2, '0, rd);
        chk("R4 fetch-ready cleared", int'(rd[1]), 0);
        access(1'b0, 2'd3, '0, rd);
        chk("R5 stale read value", int'(rd), int'(prev));
        access(1'b0, 2'd0, '0, rd);
        chk("R10 counter after consume", int'(rd), (start + k + 1) % DEPTH);
      end
      access(1'b1, 2'd1, 8'h00, rd);

      // store sweep over every address
      start = (l * 3) % DEPTH;
      access(1'b1, 2'd0, DW'(start), rd);
      access(1'b1, 2'd1, 8'h18, rd);
      for (int k = 0; k < DEPTH; k++) begin
        waitFlag(2, "R7 store-ready returns");
        access(1'b0, 2'd0, '0, rd);
        chk("R7 counter before store", int'(rd), (start + k) % DEPTH);
        access(1'b1, 2'd3, wrByte((start + k) % DEPTH, l), rd);
        access(1'b0, 2'd2, '0, rd);
        chk("R7 store-ready cleared", int'(rd[2]), 0);
        access(1'b1, 2'd3, ~wrByte((start + k) % DEPTH, l), rd);
      end
      waitFlag(2, "R7 store-ready returns");
      access(1'b0, 2'd0, '0, rd);
      chk("R10 counter wrapped after store sweep", int'(rd), start);
      access(1'b1, 2'd1, 8'h00, rd);
      for (int a = 0; a < DEPTH; a++)
        chk("R8 stored byte kept", int'(mem[a]), int'(wrByte(a, l)));
    end

    // R9 abort of a pending fetch
    lat = 3;
    refill();
    access(1'b1, 2'd0, 8'h05, rd);
    access(1'b1, 2'd1, 8'h08, rd);
    access(1'b1, 2'd1, 8'h00, rd);
    chk("R9 request dropped", int'(memReq), 0);
    repeat (6) @(posedge clk);
    access(1'b0, 2'd2, '0, rd);
    chk("R9 flags stay low after fetch abort", int'(rd), 0);
    access(1'b0, 2'd0, '0, rd);
    chk("R9 counter kept after fetch abort", int'(rd), 5);

    // R9 abort of a pending store
    access(1'b1, 2'd0, 8'h07, rd);
    access(1'b1, 2'd1, 8'h18, rd);
    access(1'b1, 2'd3, 8'hA5, rd);
    access(1'b1, 2'd1, 8'h00, rd);
    chk("R9 request dropped in store", int'(memReq), 0);
    repeat (6) @(posedge clk);
    chk("R9 aborted store not written", int'(mem[7]), int'(patByte(7)));
    access(1'b0, 2'd0, '0, rd);
    chk("R9 counter kept after store abort", int'(rd), 7);
    access(1'b0, 2'd2, '0, rd);
    chk("R9 flags low after store abort", int'(rd), 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule